// File: doc/BRIEF.md
# SDRAM Read Burst Truncation Sequencer

This block fetches a chosen number of words from an already opened SDRAM row. On a request it places a READ for the given bank and column on the command bus. When fewer words are wanted than the burst would deliver, it cuts the burst short. It does this with either a burst-stop command or a single-bank precharge, timed so that the last wanted word is still returned. It captures each returned word from the data bus and presents it on a word stream with a valid strobe. A one-cycle done pulse marks the final word.

The programmed CAS latency (2 or 3) and the burst mode (fixed length of `FIXED_BL` words, or full page) come with each request. They must match what the memory's mode register holds. The request may also set the auto-precharge bit of the READ, and may ask for the burst to be ended with precharge instead of burst stop. Chip select is assumed tied low outside the block.

Top module: `sdram_rd_trunc`

## Requirements
- R1: An accepted request puts one READ on the bus ({ras_n,cas_n,we_n} = 3'b101) in the cycle after acceptance. It carries `req_bank` on `sd_ba`, `req_col` on `sd_addr[COL_W-1:0]` and `req_auto_pre` on `sd_addr[AP_BIT]`.
- R2: When the burst is truncated with N requested words, the truncating command appears exactly N command slots after the READ slot. That is CAS latency minus one slots before the last wanted word is valid, for both latencies.
- R3: Truncation uses burst stop (3'b110) when `req_use_pre` is low. When it is high, truncation uses precharge (3'b010) with the request's bank on `sd_ba` and `sd_addr[AP_BIT]` low.
- R4: Every command slot other than the READ and the single truncating command carries NOP (3'b111).
- R5: Word k is sampled from `sd_dq_in` at the edge CL+k after the edge that samples the READ, and appears on `rd_data` with `rd_valid` in the following cycle. Exactly the effective word count is delivered.
- R6: In fixed mode with a count of at least `FIXED_BL`, no truncating command is issued and exactly `FIXED_BL` words are delivered.
- R7: In full-page mode the burst is always truncated with the requested count, even when auto precharge is set.
- R8: A request with a count of 0, or a fixed-mode request with auto precharge and a count below `FIXED_BL`, is refused. `req_err` pulses for one cycle, no command is issued and no word is delivered.
- R9: `sd_dqm` is low from the READ slot until the last word has been sampled, and high whenever the block is idle.
- R10: `rd_done` pulses for one cycle, together with `rd_valid` of the last word. `busy` falls in that same cycle.
- R11: A request presented while `busy` is high is ignored: no second READ, and the running transfer is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_bank | input | BANK_W | Bank to read |
| req_col | input | COL_W | Starting column |
| req_count | input | CNT_W | Number of words wanted |
| req_cl3 | input | 1 | 1: CAS latency 3, 0: CAS latency 2 |
| req_full_page | input | 1 | 1: full-page burst mode, 0: fixed length |
| req_auto_pre | input | 1 | Auto-precharge bit of the READ |
| req_use_pre | input | 1 | Truncate with precharge instead of burst stop |
| busy | output | 1 | Transfer in progress |
| req_err | output | 1 | One-cycle pulse on a refused request |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank address |
| sd_addr | output | ADDR_W | Address bus |
| sd_dqm | output | 1 | Data mask |
| sd_dq_in | input | DATA_W | Data from the memory |
| rd_data | output | DATA_W | Captured word |
| rd_valid | output | 1 | `rd_data` holds a word |
| rd_done | output | 1 | Last word of the transfer |

## Verification
The bench uses a memory model that stops driving real data once a burst stop or precharge takes effect, and that ends a fixed burst after `FIXED_BL` words. A truncating command issued a slot early therefore shows up as a poisoned last word. One issued late shows up as a wrong slot count. Capturing at the wrong latency shifts every word against the column pattern. The cases that matter most are a count of one, the latency difference between 2 and 3, and a fixed count at or above the burst length, where a design that still truncates would emit a stray command. A design that accepts fixed-mode auto-precharge truncation, or re-arms on a request during a transfer, would show an extra READ.

// File: rtl/sdrt_pkg.sv
package sdrt_pkg;
  // {ras_n, cas_n, we_n}, chip select held low elsewhere
  typedef enum logic [2:0] {
    CMD_PRE  = 3'b010,
    CMD_READ = 3'b101,
    CMD_BST  = 3'b110,
    CMD_NOP  = 3'b111
  } sd_cmd_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } sdrt_state_e;
endpackage

// File: rtl/sdrt_plan.sv
module sdrt_plan #(
  parameter int CNT_W    = 11,
  parameter int FIXED_BL = 8
) (
  input  logic [CNT_W-1:0] count,
  input  logic             full_page,
  input  logic             auto_pre,
  output logic             bad,
  output logic             trunc,
  output logic [CNT_W-1:0] n_eff
);
  localparam logic [CNT_W-1:0] BL = CNT_W'(FIXED_BL);

  logic short_req;

  always_comb begin
    short_req = (count < BL);
    trunc     = full_page || short_req;
    bad       = (count == '0) || (!full_page && auto_pre && short_req);
    n_eff     = trunc ? count : BL;
  end
endmodule

// File: rtl/sdrt_timer.sv
module sdrt_timer #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = cnt + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end
endmodule

// File: rtl/sdrt_capture.sv
module sdrt_capture #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic              last,
  input  logic [DATA_W-1:0] dq,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              done_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o <= '0;
    end else if (cap) begin
      data_o <= dq;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      valid_o <= cap;
      done_o  <= cap && last;
    end
  end
endmodule

// File: rtl/sdram_rd_trunc.sv
module sdram_rd_trunc
  import sdrt_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int BANK_W   = 2,
  parameter int COL_W    = 10,
  parameter int ADDR_W   = 12,
  parameter int AP_BIT   = 10,
  parameter int FIXED_BL = 8,
  parameter int CNT_W    = COL_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [COL_W-1:0]  req_col,
  input  logic [CNT_W-1:0]  req_count,
  input  logic              req_cl3,
  input  logic              req_full_page,
  input  logic              req_auto_pre,
  input  logic              req_use_pre,
  output logic              busy,
  output logic              req_err,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BANK_W-1:0] sd_ba,
  output logic [ADDR_W-1:0] sd_addr,
  output logic              sd_dqm,
  input  logic [DATA_W-1:0] sd_dq_in,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              rd_done
);
  localparam int TW = CNT_W + 2;

  sdrt_state_e       state_q, state_d;
  sd_cmd_e           cmd_q, cmd_d;
  logic [BANK_W-1:0] ba_q, ba_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              dqm_q, dqm_d;
  logic              err_q;

  logic              cl3_q, trunc_q, pre_q;
  logic [CNT_W-1:0]  neff_q;

  logic              plan_bad, plan_trunc;
  logic [CNT_W-1:0]  plan_neff;
  logic              idle, accept, reject;
  logic [TW-1:0]     cyc, cl_v, neff_ext;
  logic              run, cap, last, fire;

  sdrt_plan #(.CNT_W(CNT_W), .FIXED_BL(FIXED_BL)) u_plan (
    .count     (req_count),
    .full_page (req_full_page),
    .auto_pre  (req_auto_pre),
    .bad       (plan_bad),
    .trunc     (plan_trunc),
    .n_eff     (plan_neff)
  );

  assign idle   = (state_q == ST_IDLE);
  assign run    = (state_q == ST_RUN);
  assign accept = req_valid && idle && !plan_bad;
  assign reject = req_valid && idle && plan_bad;

  sdrt_timer #(.W(TW)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept),
    .en    (run),
    .cnt   (cyc)
  );

  // cyc holds the number of edges since the one that sampled the READ
  always_comb begin
    cl_v     = cl3_q ? TW'(3) : TW'(2);
    neff_ext = TW'(neff_q);
    cap      = run && (cyc >= cl_v) && (cyc < cl_v + neff_ext);
    last     = (cyc == cl_v + neff_ext - TW'(1));
    fire     = run && trunc_q && (cyc == neff_ext - TW'(1));
  end

  sdrt_capture #(.DATA_W(DATA_W)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap     (cap),
    .last    (last),
    .dq      (sd_dq_in),
    .data_o  (rd_data),
    .valid_o (rd_valid),
    .done_o  (rd_done)
  );

  // next-state for control and command bus
  always_comb begin
    state_d = state_q;
    cmd_d   = CMD_NOP;
    ba_d    = ba_q;
    addr_d  = addr_q;
    dqm_d   = dqm_q;
    if (accept) begin
      state_d                = ST_RUN;
      cmd_d                  = CMD_READ;
      ba_d                   = req_bank;
      addr_d                 = '0;
      addr_d[COL_W-1:0]      = req_col;
      addr_d[AP_BIT]         = req_auto_pre;
      dqm_d                  = 1'b0;
    end
    if (fire) begin
      cmd_d          = pre_q ? CMD_PRE : CMD_BST;
      addr_d[AP_BIT] = 1'b0;
    end
    if (cap && last) begin
      state_d = ST_IDLE;
      dqm_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cmd_q   <= CMD_NOP;
      ba_q    <= '0;
      addr_q  <= '0;
      dqm_q   <= 1'b1;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cmd_q   <= cmd_d;
      ba_q    <= ba_d;
      addr_q  <= addr_d;
      dqm_q   <= dqm_d;
      err_q   <= reject;
    end
  end

  // request parameters, loaded with a clock enable on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cl3_q   <= 1'b0;
      trunc_q <= 1'b0;
      pre_q   <= 1'b0;
      neff_q  <= '0;
    end else if (accept) begin
      cl3_q   <= req_cl3;
      trunc_q <= plan_trunc;
      pre_q   <= req_use_pre;
      neff_q  <= plan_neff;
    end
  end

  assign busy     = run;
  assign req_err  = err_q;
  assign sd_ras_n = cmd_q[2];
  assign sd_cas_n = cmd_q[1];
  assign sd_we_n  = cmd_q[0];
  assign sd_ba    = ba_q;
  assign sd_addr  = addr_q;
  assign sd_dqm   = dqm_q;
endmodule

// File: rtl/sdrt_checks.sv
module sdrt_checks (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic req_err,
  input logic sd_ras_n,
  input logic sd_cas_n,
  input logic sd_we_n,
  input logic sd_dqm,
  input logic rd_valid,
  input logic rd_done
);
  logic [2:0] cmd;
  assign cmd = {sd_ras_n, sd_cas_n, sd_we_n};

  assert_cmd_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'b111) || (cmd == 3'b101) || (cmd == 3'b110) || (cmd == 3'b010));

  assert_read_on_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (cmd == 3'b101));

  assert_read_only_at_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'b101) |-> $rose(busy));

  assert_refuse_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> (cmd == 3'b111) && !busy);

  assert_dqm_low_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sd_dqm);

  assert_dqm_high_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sd_dqm);

  assert_done_with_word_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> rd_valid && !busy && $past(busy));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> !rd_done);
endmodule

bind sdram_rd_trunc sdrt_checks u_sdrt_checks (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .req_err  (req_err),
  .sd_ras_n (sd_ras_n),
  .sd_cas_n (sd_cas_n),
  .sd_we_n  (sd_we_n),
  .sd_dqm   (sd_dqm),
  .rd_valid (rd_valid),
  .rd_done  (rd_done)
);

// File: tb/tb_sdram_rd_trunc.sv
module tb_sdram_rd_trunc;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 16, BANK_W = 2, COL_W = 10, ADDR_W = 12, AP_BIT = 10;
  localparam int FIXED_BL = 8, CNT_W = COL_W + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [BANK_W-1:0] req_bank = '0;
  logic [COL_W-1:0] req_col = '0;
  logic [CNT_W-1:0] req_count = '0;
  logic req_cl3 = 1'b0, req_full_page = 1'b0, req_auto_pre = 1'b0, req_use_pre = 1'b0;
  logic busy, req_err, sd_ras_n, sd_cas_n, sd_we_n, sd_dqm, rd_valid, rd_done;
  logic [BANK_W-1:0] sd_ba;
  logic [ADDR_W-1:0] sd_addr;
  logic [DATA_W-1:0] sd_dq_in = '0;
  logic [DATA_W-1:0] rd_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_rd_trunc dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bank(req_bank),
    .req_col(req_col), .req_count(req_count), .req_cl3(req_cl3),
    .req_full_page(req_full_page), .req_auto_pre(req_auto_pre),
    .req_use_pre(req_use_pre), .busy(busy), .req_err(req_err),
    .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dqm(sd_dqm), .sd_dq_in(sd_dq_in),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_done(rd_done)
  );

  int n_chk = 0, n_err = 0;

  // mode settings of the memory model, written by tasks only
  int m_cl = 2;
  bit m_full = 1'b0;

  // monitor and memory model state, written by the negedge process only
  int slot = 0;
  int n_read = 0, n_term = 0, n_bad = 0, dqm_bad = 0;
  int read_slot = 0, term_slot = 0, done_slot = 0, last_valid_slot = 0;
  int got_n = 0, done_cnt = 0, err_cnt = 0;
  logic [2:0] term_cmd = 3'b111;
  logic [ADDR_W-1:0] read_addr = '0, term_addr = '0;
  logic [BANK_W-1:0] read_ba = '0, term_ba = '0;
  logic [DATA_W-1:0] got [256];
  bit m_on = 1'b0, done_seen = 1'b1;
  int m_r = 0, m_t = -1;
  logic [BANK_W-1:0] m_ba = '0;
  logic [COL_W-1:0] m_col = '0;

  function automatic logic [DATA_W-1:0] word_of(logic [BANK_W-1:0] b, logic [COL_W-1:0] c, int k);
    logic [11:0] a;
    a = 12'(int'(c) + k);
    return 16'h8000 ^ {2'b00, b, a};
  endfunction

  always @(negedge clk) begin
    logic [2:0] cmd;
    int k, lim;
    slot = slot + 1;
    cmd = {sd_ras_n, sd_cas_n, sd_we_n};
    if (cmd == 3'b101) begin
      n_read++; read_slot = slot; read_addr = sd_addr; read_ba = sd_ba;
      m_on = 1'b1; m_r = slot; m_t = -1; m_ba = sd_ba; m_col = sd_addr[COL_W-1:0];
      done_seen = 1'b0;
    end else if (cmd == 3'b110 || cmd == 3'b010) begin
      n_term++; term_slot = slot; term_cmd = cmd; term_addr = sd_addr; term_ba = sd_ba;
      if (m_t < 0) m_t = slot;
    end else if (cmd != 3'b111) begin
      n_bad++;
    end
    if (rd_valid) begin
      got[got_n % 256] = rd_data; got_n++; last_valid_slot = slot;
    end
    if (rd_done) begin
      done_cnt++; done_slot = slot; done_seen = 1'b1;
    end
    if (req_err) err_cnt++;
    if (m_on && !done_seen && sd_dqm) dqm_bad++;
    k = slot - m_r - m_cl;
    lim = m_full ? (1 << COL_W) : FIXED_BL;
    if (m_on && k >= 0 && k < lim && (m_t < 0 || slot < m_t + m_cl))
      sd_dq_in = word_of(m_ba, m_col, k);
    else
      sd_dq_in = 16'hDEAD;
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_case(string name, int bank, int col, int cnt, bit cl3, bit full,
                          bit ap, bit pre, bit poke);
    int b_read, b_term, b_bad, b_dqm, b_got, b_done, b_err, wait_n, cl, neff, miss;
    bit bad, trunc;
    cl = cl3 ? 3 : 2;
    trunc = full || (cnt < FIXED_BL);
    bad = (cnt == 0) || (!full && ap && cnt < FIXED_BL);
    neff = trunc ? cnt : FIXED_BL;
    @(negedge clk);
    m_cl = cl; m_full = full;
    b_read = n_read; b_term = n_term; b_bad = n_bad; b_dqm = dqm_bad;
    b_got = got_n; b_done = done_cnt; b_err = err_cnt;
    req_bank = BANK_W'(bank); req_col = COL_W'(col); req_count = CNT_W'(cnt);
    req_cl3 = cl3; req_full_page = full; req_auto_pre = ap; req_use_pre = pre;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      @(negedge clk);
      req_col = COL_W'(col + 100); req_count = CNT_W'(2); req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    wait_n = 0;
    while (done_cnt == b_done && err_cnt == b_err && wait_n < 3000) begin
      @(negedge clk); wait_n++;
    end
    repeat (6) @(negedge clk);
    chk(wait_n < 3000, "R10", {name, " finished"}, wait_n, 0);
    if (bad) begin
      chk(err_cnt - b_err == 1, "R8", {name, " error pulses"}, err_cnt - b_err, 1);
      chk(n_read == b_read && n_term == b_term, "R8", {name, " commands issued"},
          n_read - b_read + n_term - b_term, 0);
      chk(got_n == b_got, "R8", {name, " words"}, got_n - b_got, 0);
      return;
    end
    chk(n_read - b_read == 1, poke ? "R11" : "R1", {name, " READ count"}, n_read - b_read, 1);
    chk(read_ba == BANK_W'(bank) && read_addr[COL_W-1:0] == COL_W'(col), "R1",
        {name, " READ column"}, int'(read_addr[COL_W-1:0]), col);
    chk(read_addr[AP_BIT] == ap, "R1", {name, " READ auto-precharge bit"},
        int'(read_addr[AP_BIT]), int'(ap));
    if (trunc) begin
      chk(n_term - b_term == 1, full ? "R7" : "R2", {name, " truncations"}, n_term - b_term, 1);
      chk(term_slot - read_slot == cnt, "R2", {name, " truncation slot"},
          term_slot - read_slot, cnt);
      chk(term_cmd == (pre ? 3'b010 : 3'b110), "R3", {name, " truncation command"},
          int'(term_cmd), pre ? 2 : 6);
      if (pre)
        chk(term_addr[AP_BIT] == 1'b0 && term_ba == BANK_W'(bank), "R3",
            {name, " precharge bank/A10"}, int'(term_addr[AP_BIT]), 0);
    end else begin
      chk(n_term == b_term, "R6", {name, " no truncation"}, n_term - b_term, 0);
    end
    chk(n_bad == b_bad, "R4", {name, " illegal commands"}, n_bad - b_bad, 0);
    chk(got_n - b_got == neff, trunc ? "R5" : "R6", {name, " word count"}, got_n - b_got, neff);
    miss = 0;
    for (int k = 0; k < neff && k < 200; k++)
      if (got[(b_got + k) % 256] !== word_of(BANK_W'(bank), COL_W'(col), k)) miss++;
    chk(miss == 0, "R5", {name, " word values"}, miss, 0);
    chk(done_cnt - b_done == 1 && done_slot == last_valid_slot, "R10",
        {name, " done with last word"}, done_slot, last_valid_slot);
    chk(done_slot - read_slot == cl + neff, "R5", {name, " last word slot"},
        done_slot - read_slot, cl + neff);
    chk(dqm_bad == b_dqm, "R9", {name, " DQM high during read"}, dqm_bad - b_dqm, 0);
    chk(!busy && sd_dqm, "R9", {name, " idle after done"}, int'(busy), 0);
  endtask

  task automatic reset_check();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({sd_ras_n, sd_cas_n, sd_we_n} == 3'b111 && sd_dqm && !busy && !rd_valid && !rd_done,
        "R4", "reset state", int'({sd_ras_n, sd_cas_n, sd_we_n}), 7);
  endtask

  initial begin
    reset_check();
    run_case("fixed cl2 n4 stop",   1, 16, 4,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0); // R2 R3
    run_case("fixed cl3 n4 stop",   2, 40, 4,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0); // R2
    run_case("full cl3 n20 ap",     3, 100, 20, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0); // R7
    run_case("fixed cl2 n3 pre",    0, 8, 3,  1'b0, 1'b0, 1'b0, 1'b1, 1'b0); // R3
    run_case("full cl2 n1 pre",     2, 500, 1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0); // R2 R3
    run_case("fixed cl3 n1 stop",   1, 3, 1,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0); // R2
    run_case("fixed cl3 n8 ap",     1, 64, 8, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0); // R6
    run_case("fixed cl2 n12",       3, 200, 12, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0); // R6
    run_case("fixed ap n5 refused", 0, 10, 5, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0); // R8
    run_case("zero count refused",  0, 10, 0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0); // R8
    run_case("busy request ignored",2, 300, 6, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1); // R11
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule